// File: doc/BRIEF.md
# Ringing-to-Talk Transition Sequencer

This controller sits on the host side of a subscriber line switch and drives its two state-select inputs, its data-latch control and an open-drain override line. The switch decodes the two inputs as {ring-select, test-select}. The sequencer can place the line in ringing, and on request it moves the line from ringing to talk using one of three styles. In the direct style the talk code is applied at once, and the switch's ring leg opens on its own at the next current zero. In the coded-gap style the all-off code is held for a programmable hold interval before talk is applied. In the override-gap style the override line is pulled low for the hold interval while the inputs change underneath it.

The hold interval is a cycle-count parameter, sized for 25 ms at the system clock. The controller reports `busy` while a gap is being timed, and it pulses `done` when the talk state has been reached. The override line is modelled as a pull-low enable. No path in the block can drive that line high, because a high level would disable the switch's thermal protection.

Top module: `line_xfer_seq`

## Requirements
- R1: After reset the select code {ring_sel_o, test_sel_o} is 2'b11 (all-off), and ovr_pull_o, busy_o and done_o are 0.
- R2: A `ring_req_i` accepted while idle in all-off or talk sets the code to 2'b10 (ringing) at the next clock edge. `talk_req_i` takes priority over `ring_req_i` when both are present in the same cycle.
- R3: With mode 2'b00 (direct), a `talk_req_i` accepted in ringing sets the code to 2'b00 at the next edge, raises `done_o` on that same edge, and never raises `busy_o`.
- R4: With mode 2'b01 (coded gap), an accepted `talk_req_i` holds code 2'b11 with `busy_o` high for exactly HOLD_CYC cycles. The code then becomes 2'b00 on the edge that drops `busy_o` and pulses `done_o`.
- R5: With mode 2'b10 (override gap), `ovr_pull_o` and `busy_o` are high for exactly HOLD_CYC cycles. During the first MID_CYC of those cycles the code stays 2'b10, and during the remaining cycles it is 2'b00. The override is released on the edge that pulses `done_o`.
- R6: `ovr_pull_o` is a pull-low enable only (1 = pull low, 0 = float). It is high only during an override-gap hold, and the select code is never all-off while it is high.
- R7: Ring and talk requests that arrive while `busy_o` is high, including in the last busy cycle, have no effect on the sequence or its timing.
- R8: A `talk_req_i` in the all-off or talk state is ignored, and the code is unchanged.
- R9: Mode 2'b11 behaves as the coded gap when SPARE_IS_GAP is 1 (the default), and as the direct style otherwise.
- R10: `latch_o` is 0 (transparent) at all times.
- R11: `done_o` is high for one cycle only, and only while the code is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_req_i | input | 1 | Request to enter ringing |
| talk_req_i | input | 1 | Request to move from ringing to talk |
| mode_i | input | 2 | Transition style, sampled together with talk_req_i |
| ring_sel_o | output | 1 | Ring-select input of the switch |
| test_sel_o | output | 1 | Test-select input of the switch |
| latch_o | output | 1 | Data-latch control of the switch, held transparent |
| ovr_pull_o | output | 1 | Pull-low enable for the open-drain override line |
| busy_o | output | 1 | A timed gap is in progress |
| done_o | output | 1 | One-cycle pulse when talk is reached |

## Verification
Two functions can fall in the same cycle: ending a gap, and accepting a new request. Requests are presented in the last busy cycle, where they must be dropped. A ring request is also presented in the cycle where `done_o` pulses. Because `busy_o` is already low in that cycle, the ring request must take effect on the next edge. A third collision is a ring request and a talk request in the same cycle, and the bench checks that the talk request wins. Each case is judged from the select code and the status outputs, sampled on every cycle that follows.

// File: rtl/lxs_pkg.sv
package lxs_pkg;
   typedef enum logic [1:0] {
      XF_DIRECT   = 2'b00,
      XF_CODE_GAP = 2'b01,
      XF_OVR_GAP  = 2'b10,
      XF_SPARE    = 2'b11
   } xfer_mode_e;

   typedef enum logic [2:0] {
      SQ_OFF   = 3'd0,
      SQ_RING  = 3'd1,
      SQ_TALK  = 3'd2,
      SQ_CGAP  = 3'd3,
      SQ_OGAP  = 3'd4
   } seq_state_e;
endpackage

// File: rtl/lxs_hold_timer.sv
module lxs_hold_timer #(
   parameter int HOLD_CYC = 25000,
   parameter int MID_CYC  = HOLD_CYC / 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic mid_o,
   output logic last_o,
   output logic past_mid_o
);
   localparam int CW = $clog2(HOLD_CYC + 1);
   localparam logic [CW-1:0] MID_AT  = CW'(MID_CYC - 1);
   localparam logic [CW-1:0] LAST_AT = CW'(HOLD_CYC - 1);

   generate
      if (HOLD_CYC < 2) begin : g_bad_hold
         $error("HOLD_CYC must be at least 2");
      end
      if (MID_CYC < 1 || MID_CYC >= HOLD_CYC) begin : g_bad_mid
         $error("MID_CYC must lie inside the hold");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          pm_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !run_i) begin
         cnt_q <= '0;
         pm_q  <= 1'b0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
         if (mid_o) pm_q <= 1'b1;
      end
   end

   assign mid_o      = run_i && (cnt_q == MID_AT);
   assign last_o     = run_i && (cnt_q == LAST_AT);
   assign past_mid_o = pm_q;
endmodule

// File: rtl/lxs_mode_map.sv
module lxs_mode_map
   import lxs_pkg::*;
#(
   parameter bit SPARE_IS_GAP = 1'b1
) (
   input  logic [1:0] mode_i,
   output xfer_mode_e mode_o
);
   generate
      if (SPARE_IS_GAP) begin : g_spare_gap
         always_comb mode_o = (mode_i == XF_SPARE) ? XF_CODE_GAP : xfer_mode_e'(mode_i);
      end else begin : g_spare_direct
         always_comb mode_o = (mode_i == XF_SPARE) ? XF_DIRECT : xfer_mode_e'(mode_i);
      end
   endgenerate
endmodule

// File: rtl/line_xfer_seq.sv
module line_xfer_seq
   import lxs_pkg::*;
#(
   parameter int HOLD_CYC     = 25000,
   parameter int MID_CYC      = HOLD_CYC / 2,
   parameter bit SPARE_IS_GAP = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ring_req_i,
   input  logic       talk_req_i,
   input  logic [1:0] mode_i,
   output logic       ring_sel_o,
   output logic       test_sel_o,
   output logic       latch_o,
   output logic       ovr_pull_o,
   output logic       busy_o,
   output logic       done_o
);
   seq_state_e st_q, st_d;
   xfer_mode_e rmode;
   logic       done_q, done_d;
   logic       tmr_mid, tmr_last, tmr_past_mid;
   logic       in_gap;

   lxs_mode_map #(.SPARE_IS_GAP(SPARE_IS_GAP)) u_map (
      .mode_i (mode_i),
      .mode_o (rmode)
   );

   assign in_gap = (st_q == SQ_CGAP) || (st_q == SQ_OGAP);

   lxs_hold_timer #(.HOLD_CYC(HOLD_CYC), .MID_CYC(MID_CYC)) u_tmr (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_i      (in_gap),
      .mid_o      (tmr_mid),
      .last_o     (tmr_last),
      .past_mid_o (tmr_past_mid)
   );

   always_comb begin
      st_d   = st_q;
      done_d = 1'b0;
      unique case (st_q)
         SQ_OFF, SQ_TALK: if (ring_req_i && !talk_req_i) st_d = SQ_RING;
         SQ_RING: begin
            if (talk_req_i) begin
               unique case (rmode)
                  XF_DIRECT:   begin st_d = SQ_TALK; done_d = 1'b1; end
                  XF_OVR_GAP:  st_d = SQ_OGAP;
                  default:     st_d = SQ_CGAP;
               endcase
            end
         end
         SQ_CGAP, SQ_OGAP: begin
            if (tmr_last) begin
               st_d   = SQ_TALK;
               done_d = 1'b1;
            end
         end
         default: st_d = SQ_OFF;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= SQ_OFF;
         done_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         done_q <= done_d;
      end
   end

   assign ring_sel_o = (st_q == SQ_OFF) || (st_q == SQ_RING) || (st_q == SQ_CGAP)
                       || ((st_q == SQ_OGAP) && !tmr_past_mid);
   assign test_sel_o = (st_q == SQ_OFF) || (st_q == SQ_CGAP);
   assign ovr_pull_o = (st_q == SQ_OGAP);
   assign busy_o     = in_gap;
   assign done_o     = done_q;
   assign latch_o    = 1'b0;

   logic unused_mid;
   assign unused_mid = tmr_mid;
endmodule

// File: rtl/line_xfer_seq_chk.sv
module line_xfer_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic ring_req_i,
   input logic talk_req_i,
   input logic ring_sel_o,
   input logic test_sel_o,
   input logic ovr_pull_o,
   input logic busy_o,
   input logic done_o
);
   assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_done_in_talk_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!ring_sel_o && !test_sel_o));

   assert_pull_only_in_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_pull_o |-> (busy_o && !test_sel_o));

   assert_code_gap_alloff_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !ovr_pull_o) |-> (ring_sel_o && test_sel_o));

   assert_pull_release_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ovr_pull_o) |-> done_o);

   assert_busy_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(talk_req_i));

   assert_ovr_no_return_ring_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_pull_o && $past(ovr_pull_o) && !$past(ring_sel_o)) |-> !ring_sel_o);

   logic unused_r;
   assign unused_r = ring_req_i;
endmodule

bind line_xfer_seq line_xfer_seq_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ring_req_i (ring_req_i),
   .talk_req_i (talk_req_i),
   .ring_sel_o (ring_sel_o),
   .test_sel_o (test_sel_o),
   .ovr_pull_o (ovr_pull_o),
   .busy_o     (busy_o),
   .done_o     (done_o)
);

// File: tb/sim_line_xfer_seq.sv
module sim_line_xfer_seq;
   localparam int CLK_PER = 10;
   localparam int HOLD    = 10;
   localparam int MID     = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ring_req = 1'b0;
   logic talk_req = 1'b0;
   logic [1:0] mode = 2'b00;
   logic ring_sel, test_sel, latch, pull, busy, done;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #(CLK_PER/2) clk = ~clk;

   line_xfer_seq #(.HOLD_CYC(HOLD), .MID_CYC(MID)) u0 (
      .clk(clk), .rst_n(rst_n), .ring_req_i(ring_req), .talk_req_i(talk_req),
      .mode_i(mode), .ring_sel_o(ring_sel), .test_sel_o(test_sel),
      .latch_o(latch), .ovr_pull_o(pull), .busy_o(busy), .done_o(done));

   // order: ring, test, pull, busy, done, latch
   task automatic chk(input string tag, input logic [5:0] exp);
      logic [5:0] act;
      act = {ring_sel, test_sel, pull, busy, done, latch};
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b (ring,test,pull,busy,done,latch)", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #1;
      ring_req = 1'b0; talk_req = 1'b0;
   endtask

   task automatic drive(input logic r, input logic t, input logic [1:0] m);
      @(negedge clk);
      ring_req = r; talk_req = t; mode = m;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1; chk("R1 reset code", 6'b110000);
      chk("R10 latch transparent", 6'b110000);
      @(negedge clk); rst_n = 1'b1;
      step(); chk("R1 idle after reset", 6'b110000);
   endtask

   task automatic t_enter_ring(input string tag);
      drive(1'b1, 1'b0, 2'b00); step();
      chk(tag, 6'b100000);
   endtask

   task automatic t_direct();
      t_reset();
      t_enter_ring("R2 ring from all-off");
      drive(1'b0, 1'b1, 2'b00); step();
      chk("R3 direct talk with done", 6'b000010);
      step(); chk("R11 done drops", 6'b000000);
      t_enter_ring("R2 ring from talk");
   endtask

   task automatic t_code_gap(input logic [1:0] m, input string tag);
      t_reset();
      t_enter_ring("R2 ring before gap");
      drive(1'b0, 1'b1, m); step();
      for (int j = 0; j < HOLD; j++) begin
         chk(tag, 6'b110100);
         if (j == 3 || j == HOLD - 1) drive(1'b1, 1'b1, 2'b00);
         else @(negedge clk);
         step();
      end
      chk("R4 talk with done after hold", 6'b000010);
      drive(1'b1, 1'b0, 2'b00); step();
      chk("R7 ring in done cycle accepted", 6'b100000);
   endtask

   task automatic t_ovr_gap();
      t_reset();
      t_enter_ring("R2 ring before override");
      drive(1'b0, 1'b1, 2'b10); step();
      for (int j = 0; j < HOLD; j++) begin
         if (j < MID) chk("R5 R6 override, ringing code", 6'b101100);
         else         chk("R5 R6 override, talk code", 6'b001100);
         if (j == 2 || j == HOLD - 1) drive(1'b1, 1'b1, 2'b01);
         else @(negedge clk);
         step();
      end
      chk("R5 release with done", 6'b000010);
      step(); chk("R11 single done after override", 6'b000000);
   endtask

   task automatic t_ignored_talk();
      t_reset();
      drive(1'b0, 1'b1, 2'b01); step();
      chk("R8 talk in all-off ignored", 6'b110000);
      drive(1'b1, 1'b1, 2'b00); step();
      chk("R2 talk wins over ring, ignored in all-off", 6'b110000);
      t_enter_ring("R2 ring");
      drive(1'b0, 1'b1, 2'b00); step(); step();
      drive(1'b0, 1'b1, 2'b10); step();
      chk("R8 talk in talk ignored", 6'b000000);
   endtask

   initial begin
      t_direct();
      t_code_gap(2'b01, "R4 coded gap holds all-off");
      t_code_gap(2'b11, "R9 spare mode as coded gap");
      t_ovr_gap();
      t_ignored_talk();
      if (!finished) begin
         finished = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      #(CLK_PER * 20000);
      if (!finished) begin
         finished = 1'b1;
         n_run++; n_fail++;
         $display("FAIL watchdog: got hang expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule